// File: doc/BRIEF.md
# Slow-Device Bus Controller with Per-Region Wait States

This block sits between a 64-bit processor-style bus and slow peripherals: a flash bank made of 16-bit parts and narrow I/O devices wired to fixed byte lanes. A transfer start is captured together with the address, direction and size. The block decodes the top address bits into one chip select per region. It drives a shared output enable for reads and eight per-lane byte write enables for writes. It then holds off the transfer acknowledge for a wait count fixed per region.

The byte write enables also serve as the write strobes of the I/O devices, and data is never moved between lanes. Each I/O region uses one of two signalling styles, set by a parameter. A direction-line region gets a chip select plus a read/write level. A strobe region gets a chip select plus separate active-low read and write strobes. A flash write narrower than 16 bits, or an address that hits no region, still completes with an acknowledge but raises an error flag.

Top module: `slow_bus_ctrl`

## Requirements
- R1: After reset all chip selects, the output enable, the byte write enables, the read and write strobes are high, the direction line is high, and ta_o and err_o are low.
- R2: The region index is addr_i[31:28]. Index 0 selects the flash and drives cs_no[0] low. Index k (1..NUM_IO) drives cs_no[k] low. At most one chip select is low, from the first cycle after the start is sampled.
- R3: ta_o is high for exactly one cycle, W+1 cycles after the clock edge that samples the start. W is the region's 4-bit wait count: flash 3, region 1 0, region 2 5, unmapped 2. With W=0 the acknowledge arrives in the first cycle after the start.
- R4: All strobes stay asserted through the acknowledge cycle and are all inactive in the cycle after it.
- R5: A read (we_i=0) to a mapped region drives oe_no low and keeps every bwe_no bit high.
- R6: A write to a mapped region drives bwe_no[k] low for each byte lane k covered by the access, and keeps oe_no high. Lane k is byte offset k within the 64-bit word. size_i codes are 0=8, 1=16, 2=32 and 3=64 bits. The covered lanes are aligned to the size using addr_i[2:0].
- R7: An 8-bit write to the flash drives no byte write enable, and raises err_o during the acknowledge cycle.
- R8: An 8-bit write to an I/O region is legal: one lane's enable goes low and err_o stays low.
- R9: Region 1 uses the direction-line style: rw_o is low during a write and high during a read, and rd_no and wr_no stay high.
- R10: Region 2 uses the strobe style: rd_no is low during a read and wr_no is low during a write, and rw_o stays high.
- R11: A start sampled while a transfer is in progress is ignored. The outputs keep the first transfer's values, only one acknowledge is issued, and no transfer follows.
- R12: An address that hits no region asserts no chip select and no strobe. It still returns ta_o after the default wait count, with err_o high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_i | input | 1 | Transfer start, active high, sampled when idle |
| addr_i | input | 32 | Byte address |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Transfer size code |
| cs_no | output | 3 | Chip selects, flash at bit 0, active low |
| oe_no | output | 1 | Shared output enable, active low |
| bwe_no | output | 8 | Byte-lane write enables, active low |
| rw_o | output | 1 | Direction line, high = read |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ta_o | output | 1 | Transfer acknowledge, one cycle |
| err_o | output | 1 | Error, valid with ta_o |

## Verification
A wrong wait counter shows up as an acknowledge one or more cycles early or late in the very transfer where it goes wrong. Every cycle is compared, so the mismatch is reported at that cycle. Bad captured strobe state appears in the first cycle after the start as a wrong chip select or lane pattern. A strobe not cleared at the acknowledge shows in the following cycle. A lost busy flag lets a second start overwrite the live transfer, and this is visible within one cycle of the ignored start.

// File: rtl/slow_bus_pkg.sv
package slow_bus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } xfer_size_e;

  localparam int unsigned LANES = 8;
  localparam int unsigned OFF_W = 3;
  localparam int unsigned WAIT_W = 4;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import slow_bus_pkg::*;
#(
  parameter int unsigned NUM_IO = 2,
  parameter int unsigned SEL_W = 4,
  parameter logic [WAIT_W*(NUM_IO+1)-1:0] WAIT_TAB = '0,
  parameter logic [WAIT_W-1:0] DEF_WAIT = 4'd2,
  parameter logic [NUM_IO-1:0] PC_MASK = '0
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NUM_IO:0]   hit_oh_o,
  output logic              hit_o,
  output logic              flash_o,
  output logic              pc_o,
  output logic [WAIT_W-1:0] wait_o
);
  localparam int unsigned NUM_REG = NUM_IO + 1;

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    assign hit_oh_o[k] = (sel_i == SEL_W'(k));
  end

  assign hit_o   = |hit_oh_o;
  assign flash_o = hit_oh_o[0];

  always_comb begin
    wait_o = hit_o ? '0 : DEF_WAIT;
    pc_o   = 1'b0;
    for (int k = 0; k < NUM_REG; k++) begin
      if (hit_oh_o[k]) wait_o = WAIT_TAB[k*WAIT_W +: WAIT_W];
    end
    for (int k = 1; k < NUM_REG; k++) begin
      if (hit_oh_o[k]) pc_o = PC_MASK[k-1];
    end
  end
endmodule

// File: rtl/sbc_lanes.sv
module sbc_lanes
  import slow_bus_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    unique case (xfer_size_e'(size_i))
      SZ_BYTE: mask_o = 8'h01 << off_i;
      SZ_HALF: mask_o = 8'h03 << {off_i[2:1], 1'b0};
      SZ_WORD: mask_o = 8'h0F << {off_i[2], 2'b00};
      default: mask_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sbc_timer.sv
module sbc_timer
  import slow_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] load_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  p_ta_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  p_start_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == $past(load_i)));
endmodule

// File: rtl/slow_bus_ctrl.sv
module slow_bus_ctrl
  import slow_bus_pkg::*;
#(
  parameter int unsigned NUM_IO = 2,
  parameter int unsigned SEL_LSB = 28,
  parameter int unsigned SEL_W = 4,
  parameter logic [WAIT_W*(NUM_IO+1)-1:0] WAIT_TAB = 12'h503,
  parameter logic [WAIT_W-1:0] DEF_WAIT = 4'd2,
  parameter logic [NUM_IO-1:0] PC_MASK = 2'b10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ts_i,
  input  logic [SEL_LSB+SEL_W-1:0] addr_i,
  input  logic                     we_i,
  input  logic [1:0]               size_i,
  output logic [NUM_IO:0]          cs_no,
  output logic                     oe_no,
  output logic [LANES-1:0]         bwe_no,
  output logic                     rw_o,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic                     ta_o,
  output logic                     err_o
);
  localparam int unsigned NUM_REG = NUM_IO + 1;

  logic [NUM_IO:0]    hit_oh;
  logic               hit, flash, pc;
  logic [WAIT_W-1:0]  wait_cnt;
  logic [LANES-1:0]   mask;
  logic               busy, done, start;
  logic               bad_flash, io_hit;

  logic [NUM_REG-1:0] cs_q;
  logic               oe_q, wdir_q, rd_q, wr_q, err_q;
  logic [LANES-1:0]   bwe_q;

  logic unused_addr;
  assign unused_addr = ^addr_i[SEL_LSB-1:OFF_W];

  sbc_decode #(
    .NUM_IO(NUM_IO), .SEL_W(SEL_W), .WAIT_TAB(WAIT_TAB),
    .DEF_WAIT(DEF_WAIT), .PC_MASK(PC_MASK)
  ) u_decode (
    .sel_i(addr_i[SEL_LSB +: SEL_W]), .hit_oh_o(hit_oh), .hit_o(hit),
    .flash_o(flash), .pc_o(pc), .wait_o(wait_cnt)
  );

  sbc_lanes u_lanes (.off_i(addr_i[OFF_W-1:0]), .size_i(size_i), .mask_o(mask));

  assign start = ts_i && !busy;

  sbc_timer u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .load_i(wait_cnt),
    .busy_o(busy), .done_o(done)
  );

  // flash parts are 16 bits wide: byte writes are refused
  assign bad_flash = flash && we_i && (xfer_size_e'(size_i) == SZ_BYTE);
  assign io_hit    = hit && !flash;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= '0; oe_q <= 1'b0; bwe_q <= '0;
      wdir_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0; err_q <= 1'b0;
    end else if (start) begin
      cs_q   <= hit_oh;
      oe_q   <= hit && !we_i;
      bwe_q  <= (hit && we_i && !bad_flash) ? mask : '0;
      wdir_q <= io_hit && !pc && we_i;
      rd_q   <= io_hit && pc && !we_i;
      wr_q   <= io_hit && pc && we_i;
      err_q  <= !hit || bad_flash;
    end else if (done) begin
      cs_q <= '0; oe_q <= 1'b0; bwe_q <= '0;
      wdir_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0; err_q <= 1'b0;
    end
  end

  assign cs_no  = ~cs_q;
  assign oe_no  = ~oe_q;
  assign bwe_no = ~bwe_q;
  assign rw_o   = ~wdir_q;
  assign rd_no  = ~rd_q;
  assign wr_no  = ~wr_q;
  assign ta_o   = done;
  assign err_o  = done && err_q;

  p_one_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  p_oe_bwe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && (bwe_no != '1)));
  p_err_with_ta_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ta_o);
  p_flash_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && bad_flash) |=> (bwe_no == '1));
  p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done && ts_i) |=> ($stable(cs_no) && $stable(bwe_no) && $stable(oe_no)));
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !ts_i) |=> (cs_no == '1 && oe_no && bwe_no == '1 && rd_no && wr_no && rw_o));
endmodule

// File: tb/slow_bus_ctrl_tb.sv
module slow_bus_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [14:0] IDLE = 15'h7FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts = 1'b0;
  logic [31:0] addr = '0;
  logic we = 1'b0;
  logic [1:0] size = '0;
  logic [2:0] cs_n;
  logic oe_n, rw, rd_n, wr_n, ta, err;
  logic [7:0] bwe_n;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slow_bus_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ts_i(ts), .addr_i(addr), .we_i(we),
    .size_i(size), .cs_no(cs_n), .oe_no(oe_n), .bwe_no(bwe_n), .rw_o(rw),
    .rd_no(rd_n), .wr_no(wr_n), .ta_o(ta), .err_o(err)
  );

  function automatic logic [14:0] mk(logic [2:0] c, logic o, logic [7:0] b,
                                     logic r, logic rdn, logic wrn);
    return {c, o, b, r, rdn, wrn};
  endfunction

  function automatic logic [14:0] outs();
    return {cs_n, oe_n, bwe_n, rw, rd_n, wr_n};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // one transfer; every cycle of it compared against the expected pins
  task automatic xfer(string req, logic [31:0] a, logic w, logic [1:0] s,
                      logic [14:0] exp, int wt, logic exp_err);
    @(negedge clk);
    ts = 1'b1; addr = a; we = w; size = s;
    @(posedge clk);
    @(negedge clk);
    ts = 1'b0;
    for (int i = 1; i <= wt + 1; i++) begin
      chk({req, " pins"}, 32'(outs()), 32'(exp));
      chk({req, " ta"}, 32'(ta), 32'(i == wt + 1));
      chk({req, " err"}, 32'(err), 32'((i == wt + 1) && exp_err));
      @(negedge clk);
    end
    chk({req, " R4 release"}, 32'({outs(), ta, err}), 32'({IDLE, 2'b00}));
  endtask

  task automatic t_reset();
    chk("R1 reset pins", 32'(outs()), 32'(IDLE));
    chk("R1 reset ta/err", 32'({ta, err}), 32'(0));
  endtask

  // second start arrives mid-transfer and must be ignored
  task automatic t_ignore();
    logic [14:0] e;
    e = mk(3'b011, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    ts = 1'b1; addr = 32'h2000_0000; we = 1'b0; size = 2'd3;
    @(posedge clk);
    @(negedge clk);
    ts = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      if (i == 2) begin
        ts = 1'b1; addr = 32'h0000_0000; we = 1'b1; size = 2'd3;
      end else begin
        ts = 1'b0;
      end
      chk("R11 pins", 32'(outs()), 32'(e));
      chk("R11 ta", 32'(ta), 32'(i == 6));
      @(negedge clk);
    end
    ts = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R11 no follow-on", 32'({outs(), ta}), 32'({IDLE, 1'b0}));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    xfer("R2 R3 R5 flash read", 32'h0000_0000, 1'b0, 2'd3,
         mk(3'b110, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1), 3, 1'b0);
    xfer("R6 flash word write", 32'h0000_0004, 1'b1, 2'd2,
         mk(3'b110, 1'b1, 8'h0F, 1'b1, 1'b1, 1'b1), 3, 1'b0);
    xfer("R6 flash half write", 32'h0000_0002, 1'b1, 2'd1,
         mk(3'b110, 1'b1, 8'hF3, 1'b1, 1'b1, 1'b1), 3, 1'b0);
    xfer("R7 flash byte write", 32'h0000_0003, 1'b1, 2'd0,
         mk(3'b110, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1), 3, 1'b1);
    xfer("R8 R9 R3 io1 byte write", 32'h1000_0005, 1'b1, 2'd0,
         mk(3'b101, 1'b1, 8'hDF, 1'b0, 1'b1, 1'b1), 0, 1'b0);
    xfer("R9 R5 io1 read", 32'h1000_0000, 1'b0, 2'd1,
         mk(3'b101, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1), 0, 1'b0);
    xfer("R10 R6 io2 half write", 32'h2000_0000, 1'b1, 2'd1,
         mk(3'b011, 1'b1, 8'hFC, 1'b1, 1'b1, 1'b0), 5, 1'b0);
    xfer("R10 io2 read", 32'h2000_0001, 1'b0, 2'd0,
         mk(3'b011, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1), 5, 1'b0);
    xfer("R6 io2 dword write", 32'h2000_0000, 1'b1, 2'd3,
         mk(3'b011, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0), 5, 1'b0);
    xfer("R12 unmapped read", 32'h7000_0000, 1'b0, 2'd3, IDLE, 2, 1'b1);
    xfer("R12 unmapped write", 32'hF000_0006, 1'b1, 2'd1, IDLE, 2, 1'b1);
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule